// File: doc/BRIEF.md
# Clock-Event Interrupt Status Controller

This block gathers status events from the monitoring logic of a clock synchroniser into sticky, write-1-clear status bits. Its inputs are plain levels: an external sync alarm, the lock flag of the secondary DPLL, the 4-bit index of the highest-priority validated input, and validity flags for two CMOS and two differential reference inputs. Each watched signal has its own trigger. The alarm triggers on a rising edge only. The lock flag triggers on either edge. The index triggers when it falls to all zeros. Each validity flag triggers on either edge.

Software reaches the bits through a small synchronous register port. A read returns data one clock after the address is presented. A write lands on the clock edge where the write enable is high. An enable register selects which validity-change bits raise the active-high interrupt request. That request stays high until every enabled, set bit has been cleared.

Top module: `clkevt_irq_ctrl`

## Requirements
- R1: After reset, address 0x0F reads 0xD0: sync-alarm bit 7, lock-change bit 6 and unqualified bit 4 are set. Addresses 0x0D and 0x10 read 0x00, and `irq_o` is 0.
- R2: Bit 7 of 0x0F sets when `sync_alarm_i` goes from 0 to 1. A 1-to-0 change leaves it unchanged.
- R3: Bit 6 of 0x0F sets on any change of `lock_i`, in either direction.
- R4: Bit 4 of 0x0F sets when `hpv_idx_i` changes from a nonzero value to 0000. Any other change of the index, or staying at zero, leaves it unchanged.
- R5: A change of `valid_i[n]` in either direction sets bit 2+n of 0x0D. The input mapping is n=0 CMOS input 1, n=1 CMOS input 2, n=2 differential input 1, n=3 differential input 2.
- R6: Writing 1 to a status bit at 0x0D or 0x0F clears that bit. Writing 0 leaves it unchanged.
- R7: The enable register at 0x10 stores `wdata[5:2]`, one bit per bit of 0x0D in the same position, and reads it back. It resets to 0.
- R8: `irq_o` is high exactly when some bit of 0x0D is set together with its enable bit at 0x10. It stays high until every such bit is cleared.
- R9: Reserved bits read as 0 and ignore writes. These are bits 5 and 3..0 of 0x0F, and bits 7..6 and 1..0 of 0x0D and 0x10. An unmapped address reads 0x00.
- R10: When a trigger event and a write-1-clear hit the same status bit on the same clock edge, the bit ends up set.
- R11: `rdata_o` shows the register selected by `addr_i` on the clock edge after the address is applied, and holds it until the next edge.
- R12: Input levels held steadily through reset cause no event once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_alarm_i | input | 1 | External sync alarm monitor level |
| lock_i | input | 1 | Secondary DPLL lock flag |
| hpv_idx_i | input | 4 | Highest-priority validated input index |
| valid_i | input | 4 | Validity flags: CMOS1, CMOS2, DIFF1, DIFF2 (bits 0..3) |
| addr_i | input | AW (8) | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A wrong edge-history register shows at the ports on the second read after the input change. It appears as a status bit that set on the wrong transition, or one that failed to set. A stuck or wrongly cleared sticky bit shows on the next read of its register, and for validity bits also on `irq_o` one edge later. Sweeping every pair of index values and every status/enable combination brings out a mismatch in the zero-detect or in the interrupt gating within a few cycles of the stimulus.

// File: rtl/clkevt_pkg.sv
package clkevt_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_ANY  = 2'd1,
    TRIG_ZERO = 2'd2
  } trig_e;

  localparam int DW = 8;
  localparam logic [7:0] VAL_ST_ADDR = 8'h0D;
  localparam logic [7:0] EVT_ST_ADDR = 8'h0F;
  localparam logic [7:0] EN_ADDR     = 8'h10;

  localparam int ALARM_BIT = 7;
  localparam int LOCK_BIT  = 6;
  localparam int UNQ_BIT   = 4;
  localparam int VAL_LSB   = 2;
  localparam int NVAL      = 4;
endpackage

// File: rtl/clkevt_trig.sv
module clkevt_trig #(
  parameter int W = 1,
  parameter clkevt_pkg::trig_e MODE = clkevt_pkg::TRIG_RISE
) (
  input  logic         clk,
  input  logic [W-1:0] sig_i,
  output logic         evt_o
);
  logic [W-1:0] prev_q;

  // History is loaded during reset too, so static levels raise no event.
  always_ff @(posedge clk) begin
    prev_q <= sig_i;
  end

  generate
    if (MODE == clkevt_pkg::TRIG_RISE) begin : g_rise
      assign evt_o = |(sig_i & ~prev_q);
    end else if (MODE == clkevt_pkg::TRIG_ANY) begin : g_any
      assign evt_o = (sig_i != prev_q);
    end else begin : g_zero
      assign evt_o = (sig_i == '0) && (prev_q != '0);
    end
  endgenerate
endmodule

// File: rtl/clkevt_sticky.sv
module clkevt_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/clkevt_irq_ctrl.sv
module clkevt_irq_ctrl #(
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sync_alarm_i,
  input  logic                      lock_i,
  input  logic [3:0]                hpv_idx_i,
  input  logic [clkevt_pkg::NVAL-1:0] valid_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [clkevt_pkg::DW-1:0] wdata_i,
  input  logic                      we_i,
  output logic [clkevt_pkg::DW-1:0] rdata_o,
  output logic                      irq_o
);
  import clkevt_pkg::*;

  localparam logic [AW-1:0] A_VAL = AW'(VAL_ST_ADDR);
  localparam logic [AW-1:0] A_EVT = AW'(EVT_ST_ADDR);
  localparam logic [AW-1:0] A_EN  = AW'(EN_ADDR);

  logic wr_val, wr_evt, wr_en;
  logic ev_alarm, ev_lock, ev_unq;
  logic [NVAL-1:0] ev_val;
  logic alarm_st, lock_st, unq_st;
  logic [NVAL-1:0] val_st;
  logic [NVAL-1:0] en_q;

  assign wr_val = we_i && (addr_i == A_VAL);
  assign wr_evt = we_i && (addr_i == A_EVT);
  assign wr_en  = we_i && (addr_i == A_EN);

  clkevt_trig #(.W(1), .MODE(TRIG_RISE)) u_trig_alarm (
    .clk(clk), .sig_i(sync_alarm_i), .evt_o(ev_alarm));
  clkevt_trig #(.W(1), .MODE(TRIG_ANY)) u_trig_lock (
    .clk(clk), .sig_i(lock_i), .evt_o(ev_lock));
  clkevt_trig #(.W(4), .MODE(TRIG_ZERO)) u_trig_unq (
    .clk(clk), .sig_i(hpv_idx_i), .evt_o(ev_unq));

  clkevt_sticky #(.RST_VAL(1'b1)) u_st_alarm (
    .clk(clk), .rst(rst), .set_i(ev_alarm),
    .clr_i(wr_evt && wdata_i[ALARM_BIT]), .q_o(alarm_st));
  clkevt_sticky #(.RST_VAL(1'b1)) u_st_lock (
    .clk(clk), .rst(rst), .set_i(ev_lock),
    .clr_i(wr_evt && wdata_i[LOCK_BIT]), .q_o(lock_st));
  clkevt_sticky #(.RST_VAL(1'b1)) u_st_unq (
    .clk(clk), .rst(rst), .set_i(ev_unq),
    .clr_i(wr_evt && wdata_i[UNQ_BIT]), .q_o(unq_st));

  generate
    for (genvar n = 0; n < NVAL; n++) begin : g_val
      clkevt_trig #(.W(1), .MODE(TRIG_ANY)) u_trig (
        .clk(clk), .sig_i(valid_i[n]), .evt_o(ev_val[n]));
      clkevt_sticky #(.RST_VAL(1'b0)) u_st (
        .clk(clk), .rst(rst), .set_i(ev_val[n]),
        .clr_i(wr_val && wdata_i[VAL_LSB+n]), .q_o(val_st[n]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wdata_i[VAL_LSB +: NVAL];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= '0;
      case (addr_i)
        A_VAL: rdata_o[VAL_LSB +: NVAL] <= val_st;
        A_EN:  rdata_o[VAL_LSB +: NVAL] <= en_q;
        A_EVT: begin
          rdata_o[ALARM_BIT] <= alarm_st;
          rdata_o[LOCK_BIT]  <= lock_st;
          rdata_o[UNQ_BIT]   <= unq_st;
        end
        default: rdata_o <= '0;
      endcase
    end
  end

  assign irq_o = |(val_st & en_q);
endmodule

// File: rtl/clkevt_irq_chk.sv
module clkevt_irq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sync_alarm_i,
  input logic          lock_i,
  input logic [3:0]    hpv_idx_i,
  input logic [3:0]    valid_i,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic          we_i,
  input logic          irq_o,
  input logic          st_alarm,
  input logic          st_lock,
  input logic          st_unq,
  input logic [3:0]    st_val,
  input logic [3:0]    st_en
);
  // R1
  rst_val_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st_alarm && st_lock && st_unq && st_val == 4'd0 && st_en == 4'd0));
  // R2
  alarm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_alarm_i) |=> st_alarm);
  // R3
  lock_any_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_i != $past(lock_i)) |=> st_lock);
  // R4
  unq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hpv_idx_i == 4'd0 && $past(hpv_idx_i) != 4'd0) |=> st_unq);
  // R5
  val_any_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i[0] != $past(valid_i[0])) |=> st_val[0]);
  // R6
  alarm_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == AW'(8'h0F) && wdata_i[7] && !$rose(sync_alarm_i)) |=> !st_alarm);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (st_val != 4'd0 && st_en != 4'd0));
endmodule

bind clkevt_irq_ctrl clkevt_irq_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .sync_alarm_i(sync_alarm_i), .lock_i(lock_i),
  .hpv_idx_i(hpv_idx_i), .valid_i(valid_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .we_i(we_i), .irq_o(irq_o),
  .st_alarm(alarm_st), .st_lock(lock_st), .st_unq(unq_st),
  .st_val(val_st), .st_en(en_q));

// File: tb/test_clkevt_irq_ctrl.sv
module test_clkevt_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_alarm_i = 1'b1;
  logic lock_i = 1'b1;
  logic [3:0] hpv_idx_i = 4'd5;
  logic [3:0] valid_i = 4'b0101;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic we_i = 1'b0;
  logic [7:0] rdata_o;
  logic irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clkevt_irq_ctrl #(.AW(8)) i_clkevt_irq_ctrl (
    .clk(clk), .rst(rst), .sync_alarm_i(sync_alarm_i), .lock_i(lock_i),
    .hpv_idx_i(hpv_idx_i), .valid_i(valid_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0; wdata_i = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    v = rdata_o;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 / R12: reset values, held levels raise no event
    rd(8'h0F, v); check("R1 evt status reset", v, 8'hD0);
    rd(8'h0D, v); check("R12 no event from held levels", v, 8'h00);
    rd(8'h10, v); check("R1 enable reset", v, 8'h00);
    check("R1 irq reset", {7'd0, irq_o}, 8'h00);
    rd(8'h0E, v); check("R9 unmapped reads zero", v, 8'h00);

    // R7 / R9: enable register
    wr(8'h10, 8'hFF); rd(8'h10, v); check("R7 R9 enable write", v, 8'h3C);
    wr(8'h10, 8'h00); rd(8'h10, v); check("R7 enable clear", v, 8'h00);

    // R6: write 0 no effect, write 1 clears
    wr(8'h0F, 8'h00); rd(8'h0F, v); check("R6 write zero keeps", v, 8'hD0);
    wr(8'h0F, 8'h80); rd(8'h0F, v); check("R6 clear bit7", v, 8'h50);
    wr(8'h0F, 8'hFF); rd(8'h0F, v); check("R6 R9 clear all", v, 8'h00);

    // R2: alarm rising only
    @(negedge clk); sync_alarm_i = 1'b0;
    rd(8'h0F, v); check("R2 falling ignored", v, 8'h00);
    @(negedge clk); sync_alarm_i = 1'b1;
    rd(8'h0F, v); check("R2 rising sets", v, 8'h80);
    wr(8'h0F, 8'h80);

    // R3: lock either edge
    @(negedge clk); lock_i = 1'b0;
    rd(8'h0F, v); check("R3 lock fall", v, 8'h40);
    wr(8'h0F, 8'h40);
    @(negedge clk); lock_i = 1'b1;
    rd(8'h0F, v); check("R3 lock rise", v, 8'h40);
    wr(8'h0F, 8'h40);

    // R4: all pairs of index values
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); hpv_idx_i = 4'(a);
        @(negedge clk);
        wr(8'h0F, 8'h10);
        hpv_idx_i = 4'(b);
        rd(8'h0F, v);
        check("R4 zero transition", v & 8'h10, (a != 0 && b == 0) ? 8'h10 : 8'h00);
      end
    end

    // R5 / R8: all status patterns against all enables
    for (int en = 0; en < 16; en++) begin
      for (int p = 0; p < 16; p++) begin
        wr(8'h0D, 8'h3C);
        wr(8'h10, 8'(en << 2));
        @(negedge clk); valid_i = valid_i ^ 4'(p);
        rd(8'h0D, v);
        check("R5 validity change", v, 8'(p << 2));
        check("R8 irq gating", {7'd0, irq_o}, ((p & en) != 0) ? 8'h01 : 8'h00);
      end
    end

    // R8: stays high until every contributing bit cleared
    wr(8'h0D, 8'h3C);
    wr(8'h10, 8'h3C);
    @(negedge clk); valid_i = valid_i ^ 4'b1001;
    rd(8'h0D, v);
    check("R8 irq set", {7'd0, irq_o}, 8'h01);
    wr(8'h0D, 8'h04);
    @(negedge clk); check("R8 irq held", {7'd0, irq_o}, 8'h01);
    wr(8'h0D, 8'h20);
    @(negedge clk); check("R8 irq released", {7'd0, irq_o}, 8'h00);

    // R10: set wins over same-edge clear
    @(negedge clk); sync_alarm_i = 1'b0;
    wr(8'h0F, 8'hD0);
    @(negedge clk);
    sync_alarm_i = 1'b1; addr_i = 8'h0F; wdata_i = 8'h80; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0; wdata_i = 8'h00;
    rd(8'h0F, v); check("R10 alarm set wins", v, 8'h80);
    wr(8'h0D, 8'h3C);
    @(negedge clk);
    valid_i[1] = ~valid_i[1]; addr_i = 8'h0D; wdata_i = 8'h08; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0; wdata_i = 8'h00;
    rd(8'h0D, v); check("R10 validity set wins", v, 8'h08);

    // R11: one-cycle read latency
    rd(8'h10, v0);
    @(negedge clk); addr_i = 8'h0F;
    #1 check("R11 data held before edge", rdata_o, v0);
    @(negedge clk); check("R11 data after edge", rdata_o, 8'h80);

    done = 1;
    finish_run();
  end
endmodule